// File: doc/BRIEF.md
# Fixed-Page Return Stack Pointer

This block produces the RAM address of the next free stack frame for subroutine calls and interrupt entries. The stack lives in a fixed page at the top of a 10-bit data address space. Each frame is four words wide. A push strobe moves the pointer down by one frame and a pop strobe moves it up by one frame. A software clear strobe, which stands for a control bit being cleared by a bit-manipulation instruction, reloads the pointer to its reset value, just as the system reset does.

Only the frame-index field of the address ever changes. The upper bits are tied to ones, so the stack stays in its page. The lower bits are also ones, because every step is a whole frame and the pointer starts from all ones. The frame index wraps modulo its width. An occupancy count beside it marks two errors: a push into a full stack and a pop from an empty one. Each raises a one-cycle flag. Neither flag stops the pointer from moving.

The strobes are plain level-sampled controls, taken on each rising clock edge. No data moves through this block, so there is no handshake and no back-pressure. The flags are plain status pulses.

Top module: `fpsp_stack_ptr`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sp_addr_o` is 0x3FF and both `ovf_o` and `unf_o` are 0. Reset is synchronous and active-high, and it overrides every strobe.
- R2: With `push_i` alone high at a rising edge, `sp_addr_o` after that edge equals its old value minus 4, taken within the frame-index field.
- R3: With `pop_i` alone high at a rising edge, `sp_addr_o` after that edge equals its old value plus 4, taken within the frame-index field.
- R4: Bits [9:6] of `sp_addr_o` are always 1111 and bits [1:0] are always 11. Only bits [5:2], the frame index, change.
- R5: The frame index wraps modulo 16. A push at 0x3C3 gives 0x3FF, and a pop at 0x3FF gives 0x3C3.
- R6: With `sp_clr_i` high at a rising edge, `sp_addr_o` after that edge is 0x3FF and the occupancy becomes zero. Push and pop strobes in the same cycle are ignored, and neither flag is raised.
- R7: A push while 16 frames are already occupied sets `ovf_o` to 1 for exactly the cycle after that edge. The pointer still moves down by 4. `ovf_o` and `unf_o` are never high together.
- R8: A pop while no frame is occupied sets `unf_o` to 1 for exactly the cycle after that edge. The pointer still moves up by 4.
- R9: With `push_i` and `pop_i` both high and `sp_clr_i` low, the address does not change and neither flag is raised.
- R10: The occupancy stays between 0 and 16. After an overflow the stack counts as full, so a further push overflows again. After an underflow it counts as empty, so a further pop underflows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high system reset |
| push_i | input | 1 | Allocate one frame (pointer down by one frame) |
| pop_i | input | 1 | Release one frame (pointer up by one frame) |
| sp_clr_i | input | 1 | Software reload of the pointer to its reset value |
| sp_addr_o | output | 10 | Address of the next frame to be used |
| ovf_o | output | 1 | One-cycle pulse: push into a full stack |
| unf_o | output | 1 | One-cycle pulse: pop from an empty stack |

## Verification
The bench uses the default parameters: a 10-bit address, four fixed upper bits and four-word frames. That gives a 4-bit frame index and a depth of 16. With this depth, a complete fill takes 16 pushes. The wrap from 0x3C3 back to 0x3FF, the overflow pulse on the 17th push and the matching underflow after 16 pops can all be reached in a few dozen cycles. A short vector table covers single steps, simultaneous strobes, the clear strobe taking priority, and an underflow from the reset state. Directed sequences then cover the full fill and drain, repeated overflow and underflow, and a reset raised in the middle of a push.

// File: rtl/fpsp_pkg.sv
package fpsp_pkg;
  // Decoded per-cycle action of the stack pointer.
  typedef enum logic [1:0] {
    SP_IDLE   = 2'd0,
    SP_PUSH   = 2'd1,
    SP_POP    = 2'd2,
    SP_RELOAD = 2'd3
  } sp_op_e;
endpackage

// File: rtl/fpsp_cmd_decode.sv
module fpsp_cmd_decode
  import fpsp_pkg::*;
(
  input  logic   push_i,
  input  logic   pop_i,
  input  logic   clr_i,
  output sp_op_e op_o
);
  // Clear wins; a push paired with a pop cancels out.
  always_comb begin
    op_o = SP_IDLE;
    if (clr_i)                op_o = SP_RELOAD;
    else if (push_i && !pop_i) op_o = SP_PUSH;
    else if (pop_i && !push_i) op_o = SP_POP;
  end
endmodule

// File: rtl/fpsp_level_reg.sv
module fpsp_level_reg
  import fpsp_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  sp_op_e           op_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_o <= '1;
    end else begin
      unique case (op_i)
        SP_RELOAD: lvl_o <= '1;
        SP_PUSH:   lvl_o <= lvl_o - ONE;
        SP_POP:    lvl_o <= lvl_o + ONE;
        default:   lvl_o <= lvl_o;
      endcase
    end
  end

  a_r2_push_step: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_PUSH) |=> (lvl_o == LVL_W'($past(lvl_o) - ONE)));

  a_r3_pop_step: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_POP) |=> (lvl_o == LVL_W'($past(lvl_o) + ONE)));

  a_r5_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_PUSH && lvl_o == '0) |=> (lvl_o == '1));

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_POP && lvl_o == '1) |=> (lvl_o == '0));
endmodule

// File: rtl/fpsp_depth_track.sv
module fpsp_depth_track
  import fpsp_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  sp_op_e op_i,
  output logic   ovf_o,
  output logic   unf_o
);
  localparam int unsigned      LEVELS = 1 << LVL_W;
  localparam int unsigned      DEP_W  = LVL_W + 1;
  localparam logic [DEP_W-1:0] FULL   = DEP_W'(LEVELS);

  logic [DEP_W-1:0] depth_q;
  logic             is_full, is_empty;

  assign is_full  = (depth_q == FULL);
  assign is_empty = (depth_q == '0);

  // Saturating occupancy: it never passes 0 or FULL.
  always_ff @(posedge clk) begin
    if (rst) begin
      depth_q <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      ovf_o <= (op_i == SP_PUSH) && is_full;
      unf_o <= (op_i == SP_POP)  && is_empty;
      unique case (op_i)
        SP_RELOAD: depth_q <= '0;
        SP_PUSH:   if (!is_full)  depth_q <= depth_q + DEP_W'(1);
        SP_POP:    if (!is_empty) depth_q <= depth_q - DEP_W'(1);
        default:   depth_q <= depth_q;
      endcase
    end
  end

  a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_PUSH && is_full) |=> ovf_o);

  a_r8_underflow: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_POP && is_empty) |=> unf_o);

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_o, unf_o}));

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (rst)
    depth_q <= FULL);

  a_r6_reload_clears: assert property (@(posedge clk) disable iff (rst)
    (op_i == SP_RELOAD) |=> (is_empty && !ovf_o && !unf_o));
endmodule

// File: rtl/fpsp_addr_form.sv
module fpsp_addr_form #(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned FIXED_W    = 4,
  parameter int unsigned FRAME_LOG2 = 2,
  localparam int unsigned LVL_W     = ADDR_W - FIXED_W - FRAME_LOG2
) (
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [ADDR_W-1:0] addr_o
);
  // Page bits tied high; offset bits inside a frame are ones because the
  // pointer starts at all ones and only ever moves in whole frames.
  generate
    if (FRAME_LOG2 > 0) begin : g_with_offset
      assign addr_o = {{FIXED_W{1'b1}}, lvl_i, {FRAME_LOG2{1'b1}}};
    end else begin : g_no_offset
      assign addr_o = {{FIXED_W{1'b1}}, lvl_i};
    end
  endgenerate
endmodule

// File: rtl/fpsp_stack_ptr.sv
module fpsp_stack_ptr
  import fpsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned FIXED_W    = 4,
  parameter int unsigned FRAME_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic              sp_clr_i,
  output logic [ADDR_W-1:0] sp_addr_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned LVL_W = ADDR_W - FIXED_W - FRAME_LOG2;
  localparam int unsigned LOW_W = ADDR_W - FIXED_W;

  sp_op_e           op;
  logic [LVL_W-1:0] lvl;

  fpsp_cmd_decode u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .clr_i  (sp_clr_i),
    .op_o   (op)
  );

  fpsp_level_reg #(.LVL_W(LVL_W)) u_lvl (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op),
    .lvl_o (lvl)
  );

  fpsp_depth_track #(.LVL_W(LVL_W)) u_dep (
    .clk   (clk),
    .rst   (rst),
    .op_i  (op),
    .ovf_o (ovf_o),
    .unf_o (unf_o)
  );

  fpsp_addr_form #(
    .ADDR_W     (ADDR_W),
    .FIXED_W    (FIXED_W),
    .FRAME_LOG2 (FRAME_LOG2)
  ) u_addr (
    .lvl_i  (lvl),
    .addr_o (sp_addr_o)
  );

  a_r4_page_fixed: assert property (@(posedge clk) disable iff (rst)
    (sp_addr_o[ADDR_W-1:LOW_W] == '1));

  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    sp_clr_i |=> (sp_addr_o == '1));

  a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !sp_clr_i) |=> ($stable(sp_addr_o) && !ovf_o && !unf_o));
endmodule

// File: tb/fpsp_stack_ptr_tb.sv
module fpsp_stack_ptr_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       push_i, pop_i, sp_clr_i;
  logic [9:0] sp_addr_o;
  logic       ovf_o, unf_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fpsp_stack_ptr dut_i (
    .clk       (clk),
    .rst       (rst),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .sp_clr_i  (sp_clr_i),
    .sp_addr_o (sp_addr_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
  );

  // Vector layout: [14]push [13]pop [12]clear [11:2]expected addr [1]ovf [0]unf
  localparam int NVEC = 12;
  localparam logic [14:0] VEC [NVEC] = '{
    {3'b100, 10'h3FB, 2'b00},  // R2 push
    {3'b100, 10'h3F7, 2'b00},  // R2 push
    {3'b010, 10'h3FB, 2'b00},  // R3 pop
    {3'b110, 10'h3FB, 2'b00},  // R9 push+pop cancel
    {3'b001, 10'h3FF, 2'b00},  // R6 clear
    {3'b010, 10'h3C3, 2'b01},  // R8/R5 pop while empty
    {3'b000, 10'h3C3, 2'b00},  // R8 pulse ends
    {3'b100, 10'h3FF, 2'b00},  // R5/R10 push after underflow
    {3'b010, 10'h3C3, 2'b00},  // R3 pop of the one frame
    {3'b101, 10'h3FF, 2'b00},  // R6 clear beats push
    {3'b011, 10'h3FF, 2'b00},  // R6 clear beats pop, no flag
    {3'b110, 10'h3FF, 2'b00}   // R9 cancel while empty
  };

  function automatic logic [9:0] frame_addr(int lvl);
    return {4'b1111, 4'(lvl), 2'b11};
  endfunction

  task automatic check(string req, logic [9:0] ea, logic eo, logic eu);
    n_run++;
    if (sp_addr_o !== ea || ovf_o !== eo || unf_o !== eu ||
        sp_addr_o[9:6] !== 4'hF || sp_addr_o[1:0] !== 2'b11) begin
      n_fail++;
      $display("FAIL %s: addr=%h ovf=%b unf=%b expected addr=%h ovf=%b unf=%b",
               req, sp_addr_o, ovf_o, unf_o, ea, eo, eu);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, sample 2 ns later.
  task automatic step(logic p, logic q, logic c);
    @(negedge clk);
    push_i = p; pop_i = q; sp_clr_i = c;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push_i = 1'b0; pop_i = 1'b0; sp_clr_i = 1'b0;
    @(posedge clk); @(posedge clk);
    #2;
    check("R1 reset hold", 10'h3FF, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; push_i = 1'b0; pop_i = 1'b0; sp_clr_i = 1'b0;
    do_reset();
    step(0, 0, 0);
    check("R1 after reset", 10'h3FF, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][14], VEC[i][13], VEC[i][12]);
      check($sformatf("vector %0d", i), VEC[i][11:2], VEC[i][1], VEC[i][0]);
    end

    // R5/R7: fill all 16 frames, then overflow twice (R10).
    do_reset();
    for (int k = 1; k <= 16; k++) begin
      step(1, 0, 0);
      check($sformatf("R2 fill %0d", k), frame_addr(15 - k), 1'b0, 1'b0);
    end
    check("R5 wrap after 16 pushes", 10'h3FF, 1'b0, 1'b0);
    step(1, 0, 0);
    check("R7 overflow push", 10'h3FB, 1'b1, 1'b0);
    step(1, 0, 0);
    check("R10 overflow again", 10'h3F7, 1'b1, 1'b0);
    step(0, 0, 0);
    check("R7 pulse ends", 10'h3F7, 1'b0, 1'b0);

    // R8/R10: drain 16 without underflow, then the next pop underflows.
    for (int k = 1; k <= 16; k++) begin
      step(0, 1, 0);
      check($sformatf("R3 drain %0d", k), frame_addr((13 + k) % 16), 1'b0, 1'b0);
    end
    step(0, 1, 0);
    check("R8 underflow after drain", 10'h3FB, 1'b0, 1'b1);
    step(0, 1, 0);
    check("R10 underflow again", 10'h3FF, 1'b0, 1'b1);

    // R1: reset wins over a push in the same cycle.
    step(1, 0, 0);
    check("R2 before reset", 10'h3FB, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1; push_i = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset overrides push", 10'h3FF, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0; push_i = 1'b0;
    step(0, 1, 0);
    check("R8 empty after reset", 10'h3C3, 1'b0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule